// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block gives a processor three 8-bit general-purpose parallel ports, called A, B and C, behind a small bus. The bus uses an 8-bit data path, a 2-bit register address, and active-low chip select, read and write strobes. A single configuration register sets the direction of each port. Port C is split into two 4-bit halves, and each half has its own direction. Only simple input and output are supported: there is no handshake, no strobing and no interrupt.

Pins are not tristate. Each port has a live input vector, an output latch vector and an output-enable vector, so the pad ring or the top level can build the tristate buffers. The configuration address accepts two kinds of word, chosen by bit 7. One kind is a configuration word that sets all directions and clears every output latch. The other kind is a command that sets or clears one port C latch bit and leaves the configuration unchanged. Output data stays in the latches after the write cycle ends. A read of an input port returns the pin values at the moment of the read.

Top module: `ppi_port_ctrl`

## Requirements
- R1: `dout_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. A read with `cs_n` high leaves `dout_oe` at 0.
- R2: Address 2'b00 reads port A, 2'b01 reads port B and 2'b10 reads port C. A read of address 2'b11 returns 8'hFF.
- R3: While `rst` is high, the configuration register takes the value 8'h9B, all output latches are cleared to 0 and every output-enable bit is 0. After reset, a read of any port returns that port's input pins.
- R4: A write to address 2'b11 with bit 7 = 1 is a configuration word. Bit 4 sets the direction of port A, bit 1 port B, bit 3 the upper half of C (bits 7:4) and bit 0 the lower half of C (bits 3:0). A direction bit of 1 means input, with output-enable 0. A direction bit of 0 means output, with all output-enable bits of that port or half set to 1. Bits 6, 5 and 2 have no effect on direction.
- R5: A configuration word clears the output latches of A, B and C to 0.
- R6: A write to address 2'b11 with bit 7 = 0 is a bit command. Bits 3:1 give the index of a port C bit (0 to 7) and bit 0 gives its new latch value. Only that one `pc_out` bit changes; every output-enable bit keeps its value.
- R7: A write to address 2'b00, 2'b01 or 2'b10 loads that port's output latch, whatever its direction, and the latch holds its value after the strobe ends. A read of a port configured as output returns its latch. A read of a port configured as input returns its live pins.
- R8: A write takes effect at the first rising clock edge where the strobe (`cs_n` and `wr_n` both low) has just gone inactive. It uses the address and data from the last clock cycle in which the strobe was active, and the result is visible after that edge. `wr_n` low while `cs_n` is high changes nothing.
- R9: On a port C read, each half is chosen on its own: a half configured as input returns its pins and a half configured as output returns its latch, within the same read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_oe | output | 1 | Drive enable for the read data |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The in-module properties are checked on every clock cycle. They cover:
- the reset values of the latches and output-enables;
- the 8'hFF readback of the configuration address;
- the latch clearing that follows a configuration word;
- the rule that a bit command changes no direction;
- the rule that nothing moves on a cycle without a write commit;
- the nibble-wide output-enables of port C.

Only the bench's scenarios can show the following:
- that each direction bit drives the right port;
- that the bit command hits the indexed bit;
- that input ports return live pins and output ports return their latches, with the two halves of C mixed;
- that a write is applied once the strobe ends.

These scenarios use directed corner cases and seeded random traffic, checked against a reference model in the bench.

// File: rtl/ppi_port_ctrl.sv
module ppi_port_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  localparam logic [7:0] CFG_RESET = 8'h9B;
  localparam logic [1:0] SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CFG = 2'd3;

  logic [7:0] cfg_q, a_q, b_q, c_q, wd_q;
  logic [1:0] wa_q;
  logic       wr_act, wr_act_q, commit;
  logic       a_in, b_in, cu_in, cl_in;

  assign wr_act = ~cs_n & ~wr_n;
  assign commit = wr_act_q & ~wr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= CFG_RESET;
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      wr_act_q <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act) begin
        wa_q <= addr;
        wd_q <= din;
      end
      if (commit) begin
        case (wa_q)
          SEL_A: a_q <= wd_q;
          SEL_B: b_q <= wd_q;
          SEL_C: c_q <= wd_q;
          default: begin
            if (wd_q[7]) begin
              cfg_q <= wd_q;
              a_q   <= '0;
              b_q   <= '0;
              c_q   <= '0;
            end else begin
              c_q[wd_q[3:1]] <= wd_q[0];
            end
          end
        endcase
      end
    end
  end

  assign a_in  = cfg_q[4];
  assign b_in  = cfg_q[1];
  assign cu_in = cfg_q[3];
  assign cl_in = cfg_q[0];

  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pc_out = c_q;
  assign pa_oe  = {8{~a_in}};
  assign pb_oe  = {8{~b_in}};
  assign pc_oe  = {{4{~cu_in}}, {4{~cl_in}}};

  assign dout_oe = ~cs_n & ~rd_n;

  always_comb begin
    case (addr)
      SEL_A:   dout = a_in ? pa_in : a_q;
      SEL_B:   dout = b_in ? pb_in : b_q;
      SEL_C:   dout = {cu_in ? pc_in[7:4] : c_q[7:4], cl_in ? pc_in[3:0] : c_q[3:0]};
      default: dout = 8'hFF;
    endcase
  end

  assert_reset_state_R3: assert property (@(posedge clk)
    rst |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00 &&
             pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00));

  assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && addr == SEL_CFG) |-> dout == 8'hFF);

  assert_cfg_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && wa_q == SEL_CFG && wd_q[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  assert_bitcmd_keeps_dir_R6: assert property (@(posedge clk) disable iff (rst)
    (commit && wa_q == SEL_CFG && !wd_q[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $countones(pc_out ^ $past(pc_out)) <= 1));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_act_q |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                   $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  assert_nibble_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) && (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF) &&
    (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF));
endmodule

// File: tb/test_ppi_port_ctrl.sv
module test_ppi_port_ctrl;
  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic dout_oe;
  int errors = 0, checks = 0;
  logic [7:0] m_cfg = 8'h9B, m_a = '0, m_b = '0, m_c = '0;

  always #5 clk = ~clk;

  ppi_port_ctrl i_ppi_port_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cfg[4] ? pa_in : m_a;
      2'd1: return m_cfg[1] ? pb_in : m_b;
      2'd2: return {m_cfg[3] ? pc_in[7:4] : m_c[7:4], m_cfg[0] ? pc_in[3:0] : m_c[3:0]};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [47:0] exp_pins();
    return {m_a, {8{~m_cfg[4]}}, m_b, {8{~m_cfg[1]}}, m_c, {{4{~m_cfg[3]}}, {4{~m_cfg[0]}}}};
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default: if (d[7]) begin m_cfg = d; m_a = 0; m_b = 0; m_c = 0; end
               else m_c[d[3:1]] = d[0];
    endcase
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1; din = ~d;
    @(negedge clk);
    model_write(a, d);
  endtask

  task automatic check_pins(input string req);
    check(req, {pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe}, exp_pins());
  endtask

  task automatic bus_read(input string req, input logic [1:0] a);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1;
    check(req, {39'd0, dout_oe, dout}, {39'd0, 1'b1, exp_read(a)});
    cs_n = 1; rd_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_pins("R3 reset pins");
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
    bus_read("R3 reset read A", 2'd0);
    bus_read("R3 reset read B", 2'd1);
    bus_read("R3 reset read C", 2'd2);
    bus_read("R2 cfg read FF", 2'd3);
    @(negedge clk); cs_n = 1; rd_n = 0; #1;
    check("R1 no oe without cs", {47'd0, dout_oe}, 48'd0);
    rd_n = 1;
    // R4: all output, mode bits set (6,5,2) must not matter
    bus_write(2'd3, 8'hE4);
    check_pins("R4 all output");
    bus_write(2'd0, 8'hA5); bus_write(2'd1, 8'h3C); bus_write(2'd2, 8'h81);
    check_pins("R7 latch hold");
    bus_read("R7 read latch A", 2'd0);
    // R8: wr_n low with cs_n high ignored
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 2'd0; din = 8'h00;
    repeat (3) @(negedge clk);
    wr_n = 1; @(negedge clk);
    check_pins("R8 no write without cs");
    // R8: commit only after strobe ends, using last active data
    @(negedge clk); cs_n = 0; wr_n = 0; addr = 2'd1; din = 8'h11;
    @(negedge clk); din = 8'h22;
    @(negedge clk);
    check("R8 not applied while active", {40'd0, pb_out}, {40'd0, 8'h3C});
    cs_n = 1; wr_n = 1;
    @(negedge clk); model_write(2'd1, 8'h22);
    check_pins("R8 last data applied");
    // R6 bit commands
    bus_write(2'd3, 8'h0F); check_pins("R6 set bit7");
    bus_write(2'd3, 8'h00); check_pins("R6 clear bit0");
    bus_write(2'd3, 8'h07); check_pins("R6 set bit3");
    // R5 config clears latches; R9 mixed C halves
    bus_write(2'd3, 8'h88);
    check_pins("R5 cfg clears");
    bus_write(2'd2, 8'h5A);
    pc_in = 8'hF0;
    bus_read("R9 C upper in lower out", 2'd2);
    bus_write(2'd3, 8'h81);
    bus_write(2'd2, 8'hC3);
    bus_read("R9 C upper out lower in", 2'd2);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      case (op)
        0: begin bus_write(2'd3, 8'($urandom) | 8'h80); check_pins("R4 R5 random cfg"); end
        1: begin bus_write(2'd3, 8'($urandom) & 8'h7F); check_pins("R6 random bitcmd"); end
        2, 3: begin
          logic [1:0] a = 2'($urandom_range(0, 2));
          bus_write(a, 8'($urandom)); check_pins("R7 random write");
        end
        default: bus_read("R2 R7 R9 random read", 2'($urandom));
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule